// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second source operand of a 32-bit data-processing instruction, together with the carry that the shifter produces. It looks at the instruction word, the value read from the operand register, the low byte of the shift-amount register and the current carry flag. From these it builds one of three operand forms: an 8-bit constant rotated right by an even amount, a register shifted by a constant amount held in the instruction, or a register shifted by an amount taken from a second register.

The carry qualifier is high only when the rotate or shift actually moved bits and so produced a new carry. When it is low, the carry output repeats the incoming flag, so the flag logic downstream can take the carry output without checking the qualifier. The operand and carry can be registered with one stage of latency, or passed through combinationally. The choice is made by a parameter. Reading the register file, the ALU and the flag storage are handled elsewhere.

Top module: `shift_operand_unit`

## Requirements
- R1: Instruction bit 25 = 1 selects the rotated-constant form; bit 25 = 0 selects a register form. In the register forms, bits 7:0 of the word are not used as a constant.
- R2: In the constant form, the operand is bits 7:0 zero-extended to 32 bits and rotated right by 2 × bits 11:8. When bits 11:8 are nonzero, carry_valid = 1 and carry_out = bit 31 of the operand.
- R3: In the constant form with bits 11:8 = 0, the operand is bits 7:0 zero-extended, carry_valid = 0 and carry_out = carry_in.
- R4: In the register forms, bits 6:5 give the shift kind (0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate right). Bit 4 = 0 takes the amount from bits 11:7. Bit 4 = 1 takes the amount from the 8-bit register byte. For amounts 1 to 31, carry_out is the last bit shifted out and carry_valid = 1.
- R5: A constant amount of 0 with a left shift gives the register value unchanged, with carry_valid = 0 and carry_out = carry_in.
- R6: A constant amount of 0 with a logical or arithmetic right shift acts as a shift by 32.
- R7: A constant amount of 0 with rotate right gives {carry_in, rm[31:1]}, with carry_out = rm[0] and carry_valid = 1.
- R8: A register amount of 0 gives the register value unchanged, with carry_valid = 0 and carry_out = carry_in.
- R9: A register amount of 32 with a left shift or logical right shift gives 0, with carry_out = rm[0] for a left shift and rm[31] for a right shift. Amounts from 33 to 255 give 0 with carry_out = 0. In both cases carry_valid = 1.
- R10: An arithmetic right shift by a register amount of 32 or more fills all 32 bits with rm[31], with carry_out = rm[31] and carry_valid = 1.
- R11: Rotate right by a register amount uses the amount modulo 32. A nonzero multiple of 32 gives rm unchanged, with carry_out = rm[31] and carry_valid = 1.
- R12: With REG_OUT = 1 the outputs show the result one clock after the inputs, and they are 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the register being shifted |
| rs_low | input | 8 | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry, or carry_in when no carry is produced |
| carry_valid | output | 1 | High when the shifter produced a carry |

## Verification
In the rotate-through-carry case, the incoming carry and the register's low bit are both in play in the same cycle. The incoming flag is shifted into operand bit 31 while rm[0] leaves as the new carry. The bench provokes this with a zero constant amount and rotate kind, under both carry_in values and register values whose bit 0 and bit 31 differ, and it checks the operand and the carry together against a bit-serial model. The register-amount sweep runs all 256 amounts under every shift kind, so the limits 0, 1, 31, 32, 33 and 255 are all included. Random words with unused fields filled in complete the set.

// File: rtl/shift_operand_unit.sv
module shift_operand_unit #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic [31:0] rm_val,
  input  logic [7:0]  rs_low,
  input  logic        carry_in,
  output logic [31:0] operand,
  output logic        carry_out,
  output logic        carry_valid
);

  localparam logic [1:0] K_LSL = 2'd0, K_LSR = 2'd1, K_ASR = 2'd2, K_ROR = 2'd3;

  logic [1:0]  kind;
  logic [7:0]  amt;
  logic        rrx;
  logic [63:0] lsl_w, lsr_w, asr_w, ror_w, imm_w;
  logic [31:0] op_n;
  logic        c_n, v_n;

  assign kind  = instr[6:5];
  assign lsl_w = {32'b0, rm_val} << amt;
  assign lsr_w = {rm_val, 32'b0} >> amt;
  assign asr_w = $signed({rm_val, 32'b0}) >>> amt;
  assign ror_w = {rm_val, rm_val} >> amt[4:0];
  assign imm_w = {24'b0, instr[7:0], 24'b0, instr[7:0]} >> {instr[11:8], 1'b0};

  always_comb begin
    rrx = 1'b0;
    amt = 8'd0;
    if (instr[4])                amt = rs_low;
    else if (instr[11:7] != 5'd0) amt = {3'b0, instr[11:7]};
    else if (kind == K_ROR)      rrx = 1'b1;
    else if (kind != K_LSL)      amt = 8'd32;
  end

  always_comb begin
    op_n = rm_val;
    c_n  = carry_in;
    v_n  = 1'b0;
    if (instr[25]) begin
      op_n = imm_w[31:0];
      v_n  = (instr[11:8] != 4'd0);
      c_n  = v_n ? imm_w[31] : carry_in;
    end else if (rrx) begin
      op_n = {carry_in, rm_val[31:1]};
      c_n  = rm_val[0];
      v_n  = 1'b1;
    end else if (amt != 8'd0) begin
      v_n = 1'b1;
      unique case (kind)
        K_LSL: begin op_n = lsl_w[31:0];  c_n = lsl_w[32]; end
        K_LSR: begin op_n = lsr_w[63:32]; c_n = lsr_w[31]; end
        K_ASR: begin op_n = asr_w[63:32]; c_n = asr_w[31]; end
        default: begin op_n = ror_w[31:0]; c_n = ror_w[31]; end
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          operand     <= '0;
          carry_out   <= 1'b0;
          carry_valid <= 1'b0;
        end else begin
          operand     <= op_n;
          carry_out   <= c_n;
          carry_valid <= v_n;
        end
      end

      p_imm_norot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25] && instr[11:8] == 4'd0) |=>
        (operand == {24'b0, $past(instr[7:0])} && !carry_valid && carry_out == $past(carry_in)));

      p_lsl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[25] && !instr[4] && instr[11:5] == 7'd0) |=>
        (operand == $past(rm_val) && !carry_valid && carry_out == $past(carry_in)));

      p_rrx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[25] && !instr[4] && instr[11:7] == 5'd0 && instr[6:5] == 2'd3) |=>
        (operand == {$past(carry_in), $past(rm_val[31:1])} && carry_out == $past(rm_val[0]) && carry_valid));

      p_reg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[25] && instr[4] && rs_low == 8'd0) |=>
        (operand == $past(rm_val) && !carry_valid && carry_out == $past(carry_in)));

      p_far_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[25] && instr[4] && rs_low > 8'd32 && !instr[6]) |=>
        (operand == 32'd0 && carry_valid && !carry_out));

      p_asr_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[25] && instr[4] && rs_low >= 8'd32 && instr[6:5] == 2'd2) |=>
        (operand == {32{$past(rm_val[31])}} && carry_out == $past(rm_val[31]) && carry_valid));
    end else begin : g_comb
      assign operand     = op_n;
      assign carry_out   = c_n;
      assign carry_valid = v_n;
    end
  endgenerate

endmodule

// File: tb/shift_operand_unit_tb_top.sv
`timescale 1ns/1ps
module shift_operand_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_low = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand;
  logic        carry_out, carry_valid;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  shift_operand_unit #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rm_val(rm_val), .rs_low(rs_low),
    .carry_in(carry_in), .operand(operand), .carry_out(carry_out), .carry_valid(carry_valid)
  );

  task automatic model(input logic [31:0] ins, input logic [31:0] rm, input logic [7:0] rs,
                       input logic cin, output logic [31:0] op, output logic c, output logic v,
                       output string tag);
    int n;
    logic [1:0] k;
    op = rm; c = cin; v = 1'b0;
    k = ins[6:5];
    if (ins[25]) begin
      op = {24'b0, ins[7:0]};
      n  = 2 * int'(ins[11:8]);
      for (int i = 0; i < n; i++) op = {op[0], op[31:1]};
      if (n != 0) begin c = op[31]; v = 1'b1; tag = "R2"; end
      else tag = "R3";
      return;
    end
    if (!ins[4]) begin
      n = int'(ins[11:7]);
      tag = "R4";
      if (n == 0) begin
        if (k == 2'd0) begin tag = "R5"; return; end
        if (k == 2'd3) begin op = {cin, rm[31:1]}; c = rm[0]; v = 1'b1; tag = "R7"; return; end
        n = 32; tag = "R6";
      end
    end else begin
      n = int'(rs);
      tag = (n == 0) ? "R8" : (n < 32) ? "R4" : (k == 2'd2) ? "R10" : (k == 2'd3) ? "R11" : "R9";
      if (n == 0) return;
    end
    v = 1'b1;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin c = op[31]; op = {op[30:0], 1'b0}; end
        2'd1: begin c = op[0];  op = {1'b0, op[31:1]}; end
        2'd2: begin c = op[0];  op = {op[31], op[31:1]}; end
        default: begin c = op[0]; op = {op[0], op[31:1]}; end
      endcase
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] rm, input logic [7:0] rs,
                       input logic cin, input string force_tag);
    logic [31:0] e_op; logic e_c, e_v; string tag;
    model(ins, rm, rs, cin, e_op, e_c, e_v, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    instr = ins; rm_val = rm; rs_low = rs; carry_in = cin;
    @(negedge clk);
    vectors++;
    if (operand !== e_op || carry_out !== e_c || carry_valid !== e_v) begin
      misses++;
      $display("FAIL %s instr=%h rm=%h rs=%0d cin=%b got op=%h c=%b v=%b exp op=%h c=%b v=%b",
               tag, ins, rm, rs, cin, operand, carry_out, carry_valid, e_op, e_c, e_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [7:0]  imms [6];
    logic [31:0] w;
    pats = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    imms = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A, 8'hC3};

    instr = 32'h0200_0FFF; rm_val = 32'hFFFF_FFFF; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    vectors++;
    if (operand !== '0 || carry_out !== 1'b0 || carry_valid !== 1'b0) begin
      misses++;
      $display("FAIL R12 reset got op=%h c=%b v=%b exp op=0 c=0 v=0", operand, carry_out, carry_valid);
    end
    rst_n = 1'b1;

    // R2 R3: every rotation of several constants; bit 25 set (R1)
    for (int r = 0; r < 16; r++)
      for (int i = 0; i < 6; i++)
        for (int ci = 0; ci < 2; ci++) begin
          w = $urandom;
          w[25] = 1'b1; w[11:8] = 4'(r); w[7:0] = imms[i];
          apply(w, $urandom, 8'($urandom), 1'(ci), "");
        end

    // R4..R7: constant amounts, all kinds
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 4; p++)
          for (int ci = 0; ci < 2; ci++) begin
            w = $urandom;
            w[25] = 1'b0; w[11:7] = 5'(a); w[6:5] = 2'(k); w[4] = 1'b0;
            apply(w, pats[p], 8'($urandom), 1'(ci), "");
          end

    // R8..R11: all register amounts including 0, 1, 31, 32, 33, 255
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++)
        for (int p = 0; p < 2; p++)
          for (int ci = 0; ci < 2; ci++) begin
            w = $urandom;
            w[25] = 1'b0; w[7] = 1'b0; w[6:5] = 2'(k); w[4] = 1'b1;
            apply(w, pats[p], 8'(a), 1'(ci), "");
          end

    // R1: random words of both forms
    for (int i = 0; i < 2000; i++) begin
      w = $urandom;
      if (!w[25] && w[4]) w[7] = 1'b0;
      apply(w, $urandom, 8'($urandom), 1'($urandom), "R1");
    end

    // R12: return to reset clears the stage
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    vectors++;
    if (operand !== '0 || carry_valid !== 1'b0) begin
      misses++;
      $display("FAIL R12 re-reset got op=%h v=%b exp op=0 v=0", operand, carry_valid);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule